// File: doc/BRIEF.md
# Dual-Rail Start-Up Sequencer with Fault Latch

This block brings up a positive supply rail and then a negative supply rail, and watches both for short circuits. When enable goes high and the input supply is above its lockout level, the positive converter starts at once with a reduced switch current limit. The negative converter follows a fixed delay later. Each rail must meet its own start-up deadline. Once both rails are up, either rail may show a short condition for a short while. If the condition lasts longer than a persistence window, a shutdown is latched.

All timing runs from a 1 µs tick input, so the parameters are given in microseconds. Analog comparators supply the rail status flags. The converter control loops are outside this block. A latched fault keeps both converters off and the supply disconnected. Two things clear it: taking enable low, or the input supply falling below the lockout level. Start-up then begins again when the block is re-enabled.

Top module: `rail_seq`

## Requirements
- R1: After enable is seen high with no under-voltage, the next cycle has pos_en=1, soft_lim=1, neg_en=0 and disconnect=0.
- R2: soft_lim drops one cycle after pos_good is seen high during positive start-up, while pos_en stays 1.
- R3: neg_en rises on the NEG_DLY_US-th tick after start-up begins, and not on any earlier tick.
- R4: If pos_good is low on the NEG_DLY_US-th tick, the fault is latched on that tick.
- R5: If neg_short is high on the NEG_DLY_US-th tick, the fault is latched on that tick, even when pos_good is high.
- R6: If neg_good is low on the NEG_OK_US-th tick since start-up began, the fault is latched on that tick.
- R7: In the running state, pos_short or neg_short must hold for PERSIST_US consecutive ticks before the fault is latched. Dropping the condition for even one cycle restarts the count.
- R8: While the fault is latched, fault=1, disconnect=1, pos_en=0 and neg_en=0. This holds as long as enable stays high and there is no under-voltage, whatever the rail flags do.
- R9: Enable low forces the off state (all enables 0, fault=0, disconnect=1) from any state. A later enable high restarts at R1.
- R10: uvlo high forces the off state from any state. When uvlo returns low with enable still high, start-up begins again at R1.
- R11: After reset the outputs are pos_en=0, neg_en=0, soft_lim=0, fault=0 and disconnect=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| en | input | 1 | Enable level |
| uvlo | input | 1 | Input supply below lockout level |
| pos_good | input | 1 | Positive rail in regulation |
| pos_short | input | 1 | Positive rail below its short threshold |
| neg_short | input | 1 | Negative rail above its short threshold |
| neg_good | input | 1 | Negative rail in regulation |
| pos_en | output | 1 | Positive converter enable |
| neg_en | output | 1 | Negative converter enable |
| soft_lim | output | 1 | Reduced switch current limit for the positive converter |
| disconnect | output | 1 | Input and outputs isolated |
| fault | output | 1 | Latched short-circuit fault |

## Verification
A clean start-up shows the tick on which the negative converter turns on, and the cycle in which the soft limit is released. Three separate start-up failures are then driven: positive rail low at the first deadline, negative short at the first deadline, and negative rail low at the second deadline. Each one shows that its own check fires on its own tick. In the running state, a short that lasts one tick too few and then clears is told apart from one that lasts the full window. The same is tried on each rail. Finally, clearing the latched fault by enable and by under-voltage shows that the latch holds against quiet rail flags and releases only on those two paths.

// File: rtl/rail_seq.sv
module rail_seq #(
  parameter int NEG_DLY_US = 8000,
  parameter int NEG_OK_US  = 16000,
  parameter int PERSIST_US = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_us,
  input  logic en,
  input  logic uvlo,
  input  logic pos_good,
  input  logic pos_short,
  input  logic neg_short,
  input  logic neg_good,
  output logic pos_en,
  output logic neg_en,
  output logic soft_lim,
  output logic disconnect,
  output logic fault
);

  localparam int TW = $clog2(NEG_OK_US + 1);
  localparam int PW = $clog2(PERSIST_US + 1);
  localparam logic [TW-1:0] NEG_LAST = TW'(NEG_DLY_US - 1);
  localparam logic [TW-1:0] OK_LAST  = TW'(NEG_OK_US - 1);
  localparam logic [PW-1:0] PER_LAST = PW'(PERSIST_US - 1);

  typedef enum logic [2:0] {S_OFF, S_POS, S_NEG, S_RUN, S_FLT} state_t;

  state_t st;
  logic [TW-1:0] since_en;
  logic [PW-1:0] short_cnt;
  logic released;

  wire go      = en && !uvlo;
  wire shorted = pos_short || neg_short;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_OFF;
      since_en  <= '0;
      short_cnt <= '0;
      released  <= 1'b0;
    end else if (!go) begin
      st        <= S_OFF;
      since_en  <= '0;
      short_cnt <= '0;
      released  <= 1'b0;
    end else begin
      case (st)
        S_OFF: begin
          st       <= S_POS;
          since_en <= '0;
          released <= 1'b0;
        end
        S_POS: begin
          if (pos_good) released <= 1'b1;
          if (tick_us) begin
            since_en <= since_en + 1'b1;
            if (since_en == NEG_LAST)
              st <= (!pos_good || neg_short) ? S_FLT : S_NEG;
          end
        end
        S_NEG: begin
          if (tick_us) begin
            since_en <= since_en + 1'b1;
            if (since_en == OK_LAST)
              st <= neg_good ? S_RUN : S_FLT;
          end
        end
        S_RUN: begin
          if (!shorted) short_cnt <= '0;
          else if (tick_us) begin
            if (short_cnt == PER_LAST) st <= S_FLT;
            else short_cnt <= short_cnt + 1'b1;
          end
        end
        default: st <= S_FLT;
      endcase
    end
  end

  assign pos_en     = (st == S_POS) || (st == S_NEG) || (st == S_RUN);
  assign neg_en     = (st == S_NEG) || (st == S_RUN);
  assign soft_lim   = (st == S_POS) && !released;
  assign fault      = (st == S_FLT);
  assign disconnect = (st == S_OFF) || (st == S_FLT);

  assert_neg_needs_pos_R3: assert property (@(posedge clk) disable iff (!rst_n)
    neg_en |-> pos_en);

  assert_softlim_only_pos_R2: assert property (@(posedge clk) disable iff (!rst_n)
    soft_lim |-> (pos_en && !neg_en));

  assert_fault_isolates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!pos_en && !neg_en && disconnect));

  assert_fault_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && en && !uvlo) |=> fault);

  assert_en_low_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pos_en && !fault && disconnect));

  assert_uvlo_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (!pos_en && !fault));

  assert_neg_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(neg_en) |-> $past(tick_us));

  assert_run_fault_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fault) && $past(neg_en)) |-> $past(tick_us));

endmodule

// File: tb/tb_rail_seq.sv
module tb_rail_seq;
  localparam int ND = 20, NO = 40, PS = 10;

  logic clk = 0, rst_n = 0, tick_us = 0, en = 0, uvlo = 0;
  logic pos_good = 0, pos_short = 0, neg_short = 0, neg_good = 0;
  logic pos_en, neg_en, soft_lim, disconnect, fault;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  rail_seq #(.NEG_DLY_US(ND), .NEG_OK_US(NO), .PERSIST_US(PS)) dut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .en(en), .uvlo(uvlo),
    .pos_good(pos_good), .pos_short(pos_short), .neg_short(neg_short),
    .neg_good(neg_good), .pos_en(pos_en), .neg_en(neg_en),
    .soft_lim(soft_lim), .disconnect(disconnect), .fault(fault));

  task automatic chk(string req, logic [4:0] exp);
    logic [4:0] act;
    act = {pos_en, neg_en, soft_lim, disconnect, fault};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {pos,neg,soft,disc,flt} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_us = 1; @(negedge clk);
      tick_us = 0; @(negedge clk);
    end
  endtask

  task automatic restart();
    en = 0; uvlo = 0; pos_good = 0; pos_short = 0; neg_short = 0; neg_good = 0;
    @(negedge clk); @(negedge clk);
    en = 1; @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11", 5'b00010);
  endtask

  task automatic t_good_start();
    restart();
    chk("R1", 5'b10100);
    ticks(3);
    pos_good = 1; @(negedge clk);
    chk("R2", 5'b10000);
    ticks(ND - 4);
    chk("R3 before delay", 5'b10000);
    ticks(1);
    chk("R3 at delay", 5'b11000);
    neg_good = 1;
    ticks(NO - ND);
    chk("R6 pass", 5'b11000);
  endtask

  task automatic t_run_short(bit on_neg);
    t_good_start();
    if (on_neg) neg_short = 1; else pos_short = 1;
    ticks(PS - 1);
    chk("R7 short window", 5'b11000);
    neg_short = 0; pos_short = 0; @(negedge clk);
    if (on_neg) neg_short = 1; else pos_short = 1;
    ticks(PS - 1);
    chk("R7 count restarted", 5'b11000);
    ticks(1);
    chk("R7 latched", 5'b00011);
    neg_short = 0; pos_short = 0; pos_good = 0; neg_good = 0;
    ticks(5);
    chk("R8 holds", 5'b00011);
  endtask

  task automatic t_pos_late();
    restart();
    ticks(ND);
    chk("R4", 5'b00011);
  endtask

  task automatic t_neg_short_start();
    restart();
    pos_good = 1; neg_short = 1;
    ticks(ND - 1);
    chk("R5 before deadline", 5'b10000);
    ticks(1);
    chk("R5", 5'b00011);
  endtask

  task automatic t_neg_late();
    restart();
    pos_good = 1;
    ticks(NO - 1);
    chk("R6 before deadline", 5'b11000);
    ticks(1);
    chk("R6", 5'b00011);
  endtask

  task automatic t_clear_en();
    t_pos_late();
    en = 0; @(negedge clk);
    chk("R9 off", 5'b00010);
    en = 1; @(negedge clk);
    chk("R9 restart", 5'b10100);
    ticks(3);
    en = 0; @(negedge clk);
    chk("R9 mid start", 5'b00010);
  endtask

  task automatic t_clear_uvlo();
    t_pos_late();
    uvlo = 1; @(negedge clk);
    chk("R10 off", 5'b00010);
    uvlo = 0; @(negedge clk);
    chk("R10 restart", 5'b10100);
  endtask

  initial begin
    fork
      begin
        @(negedge clk); @(negedge clk);
        t_reset();
        rst_n = 1; @(negedge clk);
        t_reset();
        t_good_start();
        t_run_short(0);
        t_run_short(1);
        t_pos_late();
        t_neg_short_start();
        t_neg_late();
        t_clear_en();
        t_clear_uvlo();
      end
      begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule